// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a selected input clock enable into the two timing strobes an asynchronous serial transmitter and receiver need. The first is a sampling tick at the oversampling rate. The second is a bit-rate tick at one sixteenth or one eighth of that rate. An integer divisor sets the period of the sampling tick. A three-bit fraction adds eighths of one input period on average, so the divide ratio is no longer limited to whole numbers. The fraction is applied by modulus control. A small accumulator adds the fraction once per period, and each period in which the accumulator carries out is stretched by one input enable.

All settings are captured together when the load strobe is high. The same strobe restarts the divisor counter, the fraction accumulator and the oversampling counter, so a change of settings never leaves a shortened or stretched leftover period. Both outputs are one-cycle enables in the system clock domain; the block does not produce a derived clock. The fraction takes effect only when the asynchronous-mode input is high at load time.

Top module: `fracbaud_gen`

## Requirements
- R1: With divisor D ≥ 2 and fraction F in asynchronous mode, sampling period k after a load (k = 1, 2, ...) spans D + c_k input enables, where c_k = floor(k·F/8) − floor((k−1)·F/8). Any 8 consecutive periods from the load therefore span exactly 8·D + F enables.
- R2: With F = 0, every sampling period spans exactly D input enables.
- R3: With D = 0, no sampling tick and no bit-rate tick is ever produced.
- R4: With D = 1 the divisor counter is bypassed: every accepted input enable produces a sampling tick, and F has no effect.
- R5: When the asynchronous-mode input is low at load time, F is ignored and the block divides by D alone.
- R6: The bit-rate tick is high together with every 16th sampling tick when the oversampling select is 0, and with every 8th when it is 1, counting from the load. It is never high without a sampling tick.
- R7: A load discards any partial period: neither output pulses in the cycle after the load, and counting restarts from zero with the new settings.
- R8: Only input enables advance the divisor. A sampling tick is high for the single cycle after the input enable that completes its period.
- R9: After reset both outputs are low and the divisor is 0, so no ticks appear until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture new settings and restart all counters |
| div_i | input | 16 | Integer divisor D |
| frac_i | input | 3 | Fraction F in eighths |
| over_i | input | 1 | Oversampling select: 0 = ×16, 1 = ×8 |
| async_i | input | 1 | 1 = asynchronous mode, where the fraction applies |
| clk_en_i | input | 1 | Selected input clock enable |
| samp_tick_o | output | 1 | Sampling tick, one cycle wide |
| baud_tick_o | output | 1 | Bit-rate tick, one cycle wide |

## Verification
The assertions check on every cycle that the divisor counter never passes D, that ticks follow only accepted enables, that D = 0 stays silent and D = 1 passes every enable through, that a bit-rate tick always lies on a sampling tick, and that both outputs are quiet after a load. The placement of stretched periods, the exact tick totals for each fraction and the ×16 or ×8 ratio can only be seen in the bench scenarios. These count ticks over windows sized to end just at, or one enable short of, the eighth period, and they compare the counts with values computed from the requirement formulas. The restart behaviour of a load issued in the middle of a period is also shown only by a bench scenario.

// File: rtl/fracbaud_pkg.sv
package fracbaud_pkg;

   typedef enum logic {
      OS_X16 = 1'b0,
      OS_X8  = 1'b1
   } os_sel_e;

   // last count of the oversampling stage for a given select
   function automatic int unsigned os_last(input int unsigned os_w, input os_sel_e sel);
      return (sel == OS_X8) ? ((1 << (os_w - 1)) - 1) : ((1 << os_w) - 1);
   endfunction

endpackage

// File: rtl/fb_frac_modctl.sv
module fb_frac_modctl #(
   parameter int unsigned FP_W = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_i,
   input  logic                        step_i,
   input  logic [(FP_W>0?FP_W:1)-1:0]  fp_i,
   output logic                        stretch_o
);
   localparam int unsigned AW = (FP_W > 0) ? FP_W : 1;

   generate
      if (FP_W == 0) begin : g_nofrac
         assign stretch_o = 1'b0;
      end else begin : g_frac
         logic [AW-1:0] acc_q;
         logic [AW:0]   sum;

         assign sum       = {1'b0, acc_q} + {1'b0, fp_i};
         assign stretch_o = sum[AW];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (clr_i) begin
               acc_q <= '0;
            end else if (step_i) begin
               acc_q <= sum[AW-1:0];
            end
         end

         AST_NO_STRETCH_ZERO_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
            (fp_i == '0 && acc_q == '0 && step_i && !clr_i) |=> (acc_q == '0)) // R2
            else $error("accumulator moved with zero fraction");
      end
   endgenerate
endmodule

// File: rtl/fb_period_div.sv
module fb_period_div #(
   parameter int unsigned CD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            en_i,
   input  logic [CD_W-1:0] cd_i,
   input  logic            stretch_i,
   output logic            end_o,
   output logic            counting_o
);
   localparam logic [CD_W-1:0] ONE = CD_W'(1);

   logic [CD_W-1:0] cnt_q;
   logic            idle, bypass, last;

   assign idle       = (cd_i == '0);
   assign bypass     = (cd_i == ONE);
   assign counting_o = !idle && !bypass;
   assign last       = stretch_i ? (cnt_q == cd_i) : (cnt_q == cd_i - ONE);
   assign end_o      = en_i && !idle && (bypass || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i && counting_o) begin
         cnt_q <= last ? '0 : cnt_q + ONE;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= cd_i) // R1
      else $error("divisor counter passed the divisor");

   AST_NO_EN_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !clr_i) |=> $stable(cnt_q)) // R8
      else $error("divisor counter moved without an enable");
endmodule

// File: rtl/fb_os_div.sv
module fb_os_div
   import fracbaud_pkg::*;
#(
   parameter int unsigned OS_W = 4
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clr_i,
   input  logic    step_i,
   input  os_sel_e sel_i,
   output logic    wrap_o
);
   localparam logic [OS_W-1:0] LAST16 = OS_W'(os_last(OS_W, OS_X16));
   localparam logic [OS_W-1:0] LAST8  = OS_W'(os_last(OS_W, OS_X8));

   logic [OS_W-1:0] cnt_q;
   logic [OS_W-1:0] last_val;

   assign last_val = (sel_i == OS_X8) ? LAST8 : LAST16;
   assign wrap_o   = step_i && (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= wrap_o ? '0 : cnt_q + OS_W'(1);
      end
   end

   AST_OS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last_val) // R6
      else $error("oversampling counter out of range");
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen
   import fracbaud_pkg::*;
#(
   parameter int unsigned CD_W = 16,
   parameter int unsigned FP_W = 3,
   parameter int unsigned OS_W = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   input  logic [15:0] div_i,
   input  logic [2:0]  frac_i,
   input  logic        over_i,
   input  logic        async_i,
   input  logic        clk_en_i,
   output logic        samp_tick_o,
   output logic        baud_tick_o
);
   localparam int unsigned AW = (FP_W > 0) ? FP_W : 1;
   localparam logic [CD_W-1:0] ONE = CD_W'(1);

   generate
      if (CD_W < 2 || CD_W > 16) begin : g_bad_cd
         $error("CD_W must lie in 2..16");
      end
      if (FP_W > 3) begin : g_bad_fp
         $error("FP_W must not exceed the 3-bit fraction port");
      end
      if (OS_W < 2) begin : g_bad_os
         $error("OS_W must be at least 2");
      end
   endgenerate

   // captured settings
   logic [CD_W-1:0] cd_q;
   logic [AW-1:0]   fp_q;
   os_sel_e         over_q;
   logic            async_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cd_q    <= '0;
         fp_q    <= '0;
         over_q  <= OS_X16;
         async_q <= 1'b0;
      end else if (load_i) begin
         cd_q    <= CD_W'(div_i);
         fp_q    <= AW'(frac_i);
         over_q  <= os_sel_e'(over_i);
         async_q <= async_i;
      end
   end

   logic [AW-1:0] fp_eff;
   logic          stretch, pend, counting, os_wrap, en_eff;

   assign fp_eff = async_q ? fp_q : '0;
   assign en_eff = clk_en_i && !load_i;

   fb_frac_modctl #(.FP_W(FP_W)) u_modctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (load_i),
      .step_i    (pend && counting),
      .fp_i      (fp_eff),
      .stretch_o (stretch)
   );

   fb_period_div #(.CD_W(CD_W)) u_period (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (load_i),
      .en_i       (en_eff),
      .cd_i       (cd_q),
      .stretch_i  (stretch),
      .end_o      (pend),
      .counting_o (counting)
   );

   fb_os_div #(.OS_W(OS_W)) u_os (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (load_i),
      .step_i (pend),
      .sel_i  (over_q),
      .wrap_o (os_wrap)
   );

   logic samp_q, baud_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         baud_q <= 1'b0;
      end else begin
         samp_q <= pend;
         baud_q <= os_wrap;
      end
   end

   assign samp_tick_o = samp_q;
   assign baud_tick_o = baud_q;

   AST_CD0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_q == '0) |-> (!samp_tick_o && !baud_tick_o)) // R3
      else $error("tick with zero divisor");

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_q == ONE && clk_en_i && !load_i) |=> samp_tick_o) // R4
      else $error("bypass dropped an enable");

   AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      samp_tick_o |-> $past(clk_en_i)) // R8
      else $error("sampling tick without an enable");

   AST_BAUD_ON_SAMP: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick_o |-> samp_tick_o) // R6
      else $error("bit-rate tick off a sampling tick");

   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_i) |-> (!samp_tick_o && !baud_tick_o)) // R7
      else $error("tick right after a load");
endmodule

// File: tb/tb_fracbaud_gen.sv
module tb_fracbaud_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [15:0] div_i = '0;
   logic [2:0]  frac_i = '0;
   logic        over_i = 1'b0;
   logic        async_i = 1'b0;
   logic        clk_en_i = 1'b0;
   logic        samp_tick_o, baud_tick_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int late_ticks = 0;
   bit prev_en = 1'b0;

   always #10 clk = ~clk;

   fracbaud_gen dut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .div_i(div_i), .frac_i(frac_i),
      .over_i(over_i), .async_i(async_i), .clk_en_i(clk_en_i),
      .samp_tick_o(samp_tick_o), .baud_tick_o(baud_tick_o)
   );

   typedef struct packed {
      logic [15:0] cd;
      logic [2:0]  fp;
      logic        over;
      logic        amode;
      logic [19:0] m;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      {16'd5,    3'd0, 1'b0, 1'b1, 20'd200},
      {16'd5,    3'd3, 1'b0, 1'b1, 20'd43},
      {16'd5,    3'd3, 1'b0, 1'b1, 20'd42},
      {16'd7,    3'd5, 1'b1, 1'b1, 20'd610},
      {16'd2,    3'd7, 1'b1, 1'b1, 20'd230},
      {16'd4,    3'd6, 1'b0, 1'b0, 20'd128},
      {16'd1,    3'd5, 1'b1, 1'b1, 20'd64},
      {16'd0,    3'd4, 1'b0, 1'b1, 20'd100},
      {16'd1000, 3'd1, 1'b0, 1'b1, 20'd8001},
      {16'd3,    3'd0, 1'b1, 1'b0, 20'd96}
   };

   function automatic int exp_samp(int cd, int fp, bit amode, int m);
      int f;
      int k;
      if (cd == 0) return 0;
      if (cd == 1) return m;
      f = amode ? fp : 0;
      k = 0;
      while ((k + 1) * cd + ((k + 1) * f) / 8 <= m) k++;
      return k;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // sample outputs at the falling edge, then set the enable for the next rising edge
   task automatic sample(inout int ns, inout int nb, input bit next_en);
      @(negedge clk);
      if (samp_tick_o && !prev_en) late_ticks++;
      ns += int'(samp_tick_o);
      nb += int'(baud_tick_o);
      clk_en_i = next_en;
      prev_en  = next_en;
   endtask

   task automatic do_load(int cd, int fp, bit ov, bit amode);
      int dummy_s = 0;
      int dummy_b = 0;
      sample(dummy_s, dummy_b, 1'b0);
      div_i   = 16'(cd);
      frac_i  = 3'(fp);
      over_i  = ov;
      async_i = amode;
      load_i  = 1'b1;
      @(negedge clk);
      load_i  = 1'b0;
      prev_en = 1'b0;
   endtask

   task automatic run(int n_en, int gap, output int ns, output int nb);
      ns = 0;
      nb = 0;
      for (int i = 0; i < n_en; i++) begin
         sample(ns, nb, 1'b1);
         for (int g = 0; g < gap; g++) sample(ns, nb, 1'b0);
      end
      sample(ns, nb, 1'b0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int ns;
      int nb;
      int es;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state, no ticks before any load even with enables
      run(40, 0, ns, nb);
      chk("R9 reset samp", ns, 0);
      chk("R9 reset baud", nb, 0);

      // table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         do_load(int'(VEC[v].cd), int'(VEC[v].fp), VEC[v].over, VEC[v].amode);
         run(int'(VEC[v].m), 0, ns, nb);
         es = exp_samp(int'(VEC[v].cd), int'(VEC[v].fp), VEC[v].amode, int'(VEC[v].m));
         chk($sformatf("R1/R2/R3/R4/R5 samp vec%0d", v), ns, es);
         chk($sformatf("R6 baud vec%0d", v), nb, es / (VEC[v].over ? 8 : 16));
      end

      // R1: every fraction, eight periods end exactly at 8*D+F enables
      for (int f = 0; f < 8; f++) begin
         do_load(6, f, 1'b1, 1'b1);
         run(48 + f, 0, ns, nb);
         chk($sformatf("R1 fp=%0d full", f), ns, 8);
         chk($sformatf("R6 fp=%0d baud", f), nb, 1);
         do_load(6, f, 1'b1, 1'b1);
         run(47 + f, 0, ns, nb);
         chk($sformatf("R1 fp=%0d short", f), ns, 7);
      end

      // R7: a load in mid-period restarts counting
      do_load(9, 0, 1'b0, 1'b1);
      run(5, 0, ns, nb);
      chk("R7 partial before reload", ns, 0);
      do_load(9, 0, 1'b0, 1'b1);
      run(8, 0, ns, nb);
      chk("R7 no early tick after reload", ns, 0);
      run(1, 0, ns, nb);
      chk("R7 tick on ninth enable", ns, 1);

      // R8: sparse enables, ticks follow enables only
      late_ticks = 0;
      do_load(4, 0, 1'b1, 1'b1);
      run(64, 2, ns, nb);
      chk("R8 sparse samp", ns, 16);
      chk("R8 sparse baud", nb, 2);
      chk("R8 tick only after enable", late_ticks, 0);

      // R5: same fraction, mode off vs on
      do_load(3, 4, 1'b0, 1'b0);
      run(27, 0, ns, nb);
      chk("R5 mode off ignores fraction", ns, 9);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule